// File: doc/BRIEF.md
# Serial Port with Byte Queues on a Peripheral Bus

This block is a byte-wide asynchronous serial transmitter and receiver. A host reaches it through five word registers on an APB slave port. Characters written to the data word wait in a transmit queue. They leave on `txd` as frames of one start bit, eight data bits sent LSB first, an optional parity bit and one stop bit. Frames arriving on `rxd` are checked, then stored in a receive queue, and each read of the data word takes one byte from that queue.

A 12-bit reload value sets the bit rate. A tick occurs every reload+1 clocks, and one bit lasts eight ticks. The status word reports the following:
- both queue fill counts,
- empty, half and full levels for each queue,
- four sticky error flags, which any status write clears.

One interrupt line combines several enabled sources: received data, a transmit-queue level, and a single-cycle pulse when the transmit queue drains. A loopback bit connects the transmitter output to the receiver input inside the block. The flow-control, external-clock, debug and delayed-interrupt control bits are stored and read back but have no effect.

Register offsets are 0x00 data, 0x04 status, 0x08 control, 0x0C scaler and 0x10 debug (the debug word reads zero).

Top module: `apb_uart_top`

## Requirements
- R1: After reset, control reads 0x8000_0000 (bit 31 = queues present, every enable clear) and status reads 0x0000_0086 (bit 1 transmitter idle, bit 2 TX queue empty, bit 7 TX at or below half). `txd` is high and `irq` is low.
- R2: With loopback (control bit 7), TX enable (bit 1) and RX enable (bit 0) set, bytes written to offset 0x00 are read back from 0x00 in the order written. Status bit 0 is set while the RX queue holds a byte.
- R3: Control bit 5 enables parity and bit 4 selects odd (1) or even (0). The transmitted parity bit makes the count of ones even or odd accordingly. A received frame whose parity bit does not match sets status bit 5, and its byte is still stored.
- R4: A frame is a low start bit, eight data bits LSB first, the parity bit when enabled, and a high stop bit. Every bit lasts 8*(reload+1) clocks, where reload is scaler bits 11:0. The line is high when no frame is being sent.
- R5: Any write to the status offset clears the sticky flags in status bits 3 to 6.
- R6: A frame with a low stop bit and nonzero data sets the framing flag (status bit 6), and its byte is still stored.
- R7: A frame that is low for its whole length (zero data, zero parity, low stop) sets the break flag (status bit 3) and stores no byte.
- R8: A byte that arrives while the RX queue is full is dropped and sets overrun (status bit 4). Status bit 10 shows RX full, bit 8 shows RX count of at least DEPTH/2, and bits 31:26 hold the RX count.
- R9: A data write while the TX queue is full is dropped. Status bit 9 shows TX full and bits 25:20 hold the TX count. No frame starts while TX enable is clear.
- R10: The receiver ignores a low pulse shorter than half a bit. It also ignores the line while RX enable is clear.
- R11: `irq` is high while RX interrupt enable (control bit 2) and data ready are both set. It is high while TX-queue interrupt enable (bit 9) is set and the TX count is at most DEPTH/2. With TX interrupt enable (bit 3) set, it pulses for exactly one cycle when the TX queue goes from non-empty to empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and core clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses three stimulus patterns, and each one separates a different kind of fault.

- **Loopback bursts** (a short run of bytes, then a run long enough to fill a queue) expose ordering and count faults.
- **Frames driven directly on `rxd`** isolate the receiver's decisions. These include correct parity, wrong parity, a low stop bit, an all-low frame, a short glitch and a frame sent with the receiver disabled. Each one sets exactly one flag or none.
- **Single frames captured from `txd`** with bytes whose LSB is 1 let the bench time the start bit against the reload value and read the parity bit for both parity senses.

// File: rtl/uart_apb_pkg.sv
package uart_apb_pkg;
  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_STAT = 5'h04;
  localparam logic [4:0] A_CTRL = 5'h08;
  localparam logic [4:0] A_SCAL = 5'h0C;
  localparam logic [4:0] A_DBG  = 5'h10;

  localparam int CTRL_W = 15;
  localparam int C_RXEN = 0;
  localparam int C_TXEN = 1;
  localparam int C_RIE  = 2;
  localparam int C_TIE  = 3;
  localparam int C_PODD = 4;
  localparam int C_PEN  = 5;
  localparam int C_LOOP = 7;
  localparam int C_TFIE = 9;
  localparam int C_RFIE = 10;
  localparam int C_BIE  = 12;
  localparam int C_SIE  = 14;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

  // packed so that it lands on status bits 6..3 directly
  typedef struct packed {
    logic fe;
    logic pe;
    logic ov;
    logic br;
  } err_flags_t;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int RELOAD_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RELOAD_W-1:0] reload,
  output logic                tick
);
  logic [RELOAD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                wdata,
  input  logic                         pop,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  always_comb begin
    do_push = push && (cnt_q != CW'(DEPTH));
    do_pop  = pop && (cnt_q != '0);
    wp_d    = wp_q;
    rp_d    = rp_q;
    cnt_d   = cnt_q;
    if (do_push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (!do_push && do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign count = cnt_q;
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       has_data,
  input  logic [7:0] data,
  output logic       pop,
  output logic       txd,
  output logic       idle
);
  logic        busy_q, busy_d;
  logic [10:0] sh_q, sh_d;
  logic [2:0]  sub_q, sub_d;
  logic [3:0]  bit_q, bit_d;
  logic        par;
  logic [3:0]  last_bit;

  always_comb begin
    par      = (^data) ^ par_odd;
    last_bit = par_en ? 4'd10 : 4'd9;
    busy_d   = busy_q;
    sh_d     = sh_q;
    sub_d    = sub_q;
    bit_d    = bit_q;
    pop      = 1'b0;
    if (!busy_q) begin
      // frames start on a tick so every bit spans exactly eight ticks
      if (tick && enable && has_data) begin
        pop    = 1'b1;
        busy_d = 1'b1;
        sh_d   = {1'b1, (par_en ? par : 1'b1), data, 1'b0};
        sub_d  = 3'd0;
        bit_d  = 4'd0;
      end
    end else if (tick) begin
      sub_d = sub_q + 3'd1;
      if (sub_q == 3'd7) begin
        sh_d  = {1'b1, sh_q[10:1]};
        bit_d = bit_q + 4'd1;
        if (bit_q == last_bit) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign idle = !busy_q;
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_apb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       enable,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rx_in,
  output logic       push,
  output logic [7:0] data,
  output logic       set_pe,
  output logic       set_fe,
  output logic       set_br,
  output logic       idle
);
  rx_state_e  state_q, state_d;
  logic       armed_q, armed_d;
  logic [2:0] sub_q, sub_d;
  logic [2:0] idx_q, idx_d;
  logic [7:0] sh_q, sh_d;
  logic       perr_q, perr_d;
  logic       pbit_q, pbit_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    sub_d   = sub_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    perr_d  = perr_q;
    pbit_d  = pbit_q;
    push    = 1'b0;
    set_pe  = 1'b0;
    set_fe  = 1'b0;
    set_br  = 1'b0;
    if (tick) begin
      case (state_q)
        RX_IDLE: begin
          // a new start is accepted only after the line has been seen high
          if (rx_in) armed_d = 1'b1;
          else if (armed_q && enable) begin
            state_d = RX_START;
            sub_d   = 3'd0;
          end
        end
        RX_START: begin
          sub_d = sub_q + 3'd1;
          if (sub_q == 3'd3) begin
            sub_d   = 3'd0;
            idx_d   = 3'd0;
            perr_d  = 1'b0;
            pbit_d  = 1'b0;
            state_d = rx_in ? RX_IDLE : RX_DATA;
          end
        end
        RX_DATA: begin
          sub_d = sub_q + 3'd1;
          if (sub_q == 3'd7) begin
            sh_d  = {rx_in, sh_q[7:1]};
            idx_d = idx_q + 3'd1;
            if (idx_q == 3'd7) state_d = par_en ? RX_PAR : RX_STOP;
          end
        end
        RX_PAR: begin
          sub_d = sub_q + 3'd1;
          if (sub_q == 3'd7) begin
            pbit_d  = rx_in;
            perr_d  = rx_in ^ (^sh_q) ^ par_odd;
            state_d = RX_STOP;
          end
        end
        default: begin
          sub_d = sub_q + 3'd1;
          if (sub_q == 3'd7) begin
            state_d = RX_IDLE;
            armed_d = rx_in;
            if (!rx_in && (sh_q == 8'h00) && !pbit_q) set_br = 1'b1;
            else begin
              push   = 1'b1;
              set_fe = !rx_in;
              set_pe = perr_q;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      armed_q <= 1'b0;
      sub_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      perr_q  <= 1'b0;
      pbit_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      sub_q   <= sub_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      perr_q  <= perr_d;
      pbit_q  <= pbit_d;
    end
  end

  assign data = sh_q;
  assign idle = (state_q == RX_IDLE);
endmodule

// File: rtl/apb_uart_top.sv
module apb_uart_top
  import uart_apb_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int RELOAD_W   = 12
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [4:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        rxd,
  output logic        txd,
  output logic        irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int HALF  = FIFO_DEPTH / 2;

  logic rst_meta_q, rst_n;
  logic rxd_s1_q, rxd_s2_q;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [RELOAD_W-1:0] reload_q, reload_d;
  err_flags_t          err_q, err_d;
  logic [CNT_W-1:0]    txc_prev_q;

  logic wr_en, rd_en, stat_wr, tx_push, rx_pop;
  logic tick, tx_pop, tx_idle, txd_int, rx_line;
  logic rx_push, rx_idle, set_pe, set_fe, set_br;
  logic [7:0] tx_head, rx_byte, rx_head;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_empty, tx_full, tx_half, rx_full, rx_half, rx_ready, ti_pulse;
  logic [31:0] status;
  logic unused_wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) {rst_n, rst_meta_q} <= 2'b00;
    else          {rst_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) {rxd_s2_q, rxd_s1_q} <= 2'b11;
    else        {rxd_s2_q, rxd_s1_q} <= {rxd_s1_q, rxd};
  end

  assign wr_en   = psel && penable && pwrite;
  assign rd_en   = psel && penable && !pwrite;
  assign stat_wr = wr_en && (paddr == A_STAT);
  assign tx_push = wr_en && (paddr == A_DATA);
  assign rx_pop  = rd_en && (paddr == A_DATA);
  assign rx_line = ctrl_q[C_LOOP] ? txd_int : rxd_s2_q;
  assign unused_wdata = ^pwdata[31:CTRL_W];

  uart_tick_gen #(.RELOAD_W(RELOAD_W)) u_tick (
    .clk(pclk), .rst_n(rst_n), .reload(reload_q), .tick(tick));

  uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_txq (
    .clk(pclk), .rst_n(rst_n), .push(tx_push), .wdata(pwdata[7:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_cnt));

  uart_tx_ser u_tx (
    .clk(pclk), .rst_n(rst_n), .tick(tick), .enable(ctrl_q[C_TXEN]),
    .par_en(ctrl_q[C_PEN]), .par_odd(ctrl_q[C_PODD]), .has_data(!tx_empty),
    .data(tx_head), .pop(tx_pop), .txd(txd_int), .idle(tx_idle));

  uart_rx_deser u_rx (
    .clk(pclk), .rst_n(rst_n), .tick(tick), .enable(ctrl_q[C_RXEN]),
    .par_en(ctrl_q[C_PEN]), .par_odd(ctrl_q[C_PODD]), .rx_in(rx_line),
    .push(rx_push), .data(rx_byte), .set_pe(set_pe), .set_fe(set_fe),
    .set_br(set_br), .idle(rx_idle));

  uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_rxq (
    .clk(pclk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_cnt));

  always_comb begin
    tx_empty = (tx_cnt == '0);
    tx_full  = (tx_cnt == CNT_W'(FIFO_DEPTH));
    tx_half  = (tx_cnt <= CNT_W'(HALF));
    rx_ready = (rx_cnt != '0);
    rx_full  = (rx_cnt == CNT_W'(FIFO_DEPTH));
    rx_half  = (rx_cnt >= CNT_W'(HALF));
    ti_pulse = ctrl_q[C_TIE] && tx_empty && (txc_prev_q != '0);
    status   = {6'(rx_cnt), 6'(tx_cnt), 9'd0, rx_full, tx_full, rx_half,
                tx_half, err_q, tx_empty, tx_idle, rx_ready};
    irq = (ctrl_q[C_RIE] && rx_ready) || ti_pulse ||
          (ctrl_q[C_TFIE] && tx_half) || (ctrl_q[C_RFIE] && rx_half) ||
          (ctrl_q[C_BIE] && err_q.br) || (ctrl_q[C_SIE] && tx_empty && tx_idle);
  end

  always_comb begin
    case (paddr)
      A_DATA:  prdata = {24'd0, rx_head};
      A_STAT:  prdata = status;
      A_CTRL:  prdata = {1'b1, (31 - CTRL_W)'(0), ctrl_q};
      A_SCAL:  prdata = 32'(reload_q);
      A_DBG:   prdata = 32'd0;
      default: prdata = 32'd0;
    endcase
  end

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    err_d    = err_q;
    if (wr_en && (paddr == A_CTRL)) ctrl_d   = pwdata[CTRL_W-1:0];
    if (wr_en && (paddr == A_SCAL)) reload_d = pwdata[RELOAD_W-1:0];
    if (stat_wr) err_d = '0;
    if (set_br)              err_d.br = 1'b1;
    if (rx_push && rx_full)  err_d.ov = 1'b1;
    if (set_pe)              err_d.pe = 1'b1;
    if (set_fe)              err_d.fe = 1'b1;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      reload_q   <= '0;
      err_q      <= '0;
      txc_prev_q <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      reload_q   <= reload_d;
      err_q      <= err_d;
      txc_prev_q <= tx_cnt;
    end
  end

  assign txd = txd_int;
endmodule

// File: rtl/uart_apb_checker.sv
module uart_apb_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             irq,
  input logic             tx_idle,
  input logic             rx_idle,
  input logic             ri_en,
  input logic             stat_wr,
  input logic             ti_pulse,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt,
  input logic [3:0]       err
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> txd); // R4

  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH)); // R9

  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH)); // R8

  AST_RX_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_en && rx_cnt != '0) |-> irq); // R11

  AST_TX_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ti_pulse |=> !ti_pulse); // R11

  AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && rx_idle) |=> (err == 4'd0)); // R5
endmodule

bind apb_uart_top uart_apb_checker #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(pclk), .rst_n(rst_n), .txd(txd), .irq(irq), .tx_idle(tx_idle),
  .rx_idle(rx_idle), .ri_en(ctrl_q[2]), .stat_wr(stat_wr), .ti_pulse(ti_pulse),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .err(err_q));

// File: tb/apb_uart_top_bench.sv
`timescale 1ns/1ps
module apb_uart_top_bench;
  localparam int DEPTH  = 8;
  localparam int RELOAD = 2;
  localparam int BP     = 8 * (RELOAD + 1);

  logic        pclk, presetn, psel, penable, pwrite, rxd;
  logic [4:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        txd, irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  logic [7:0] expq[$];

  apb_uart_top #(.FIFO_DEPTH(DEPTH), .RELOAD_W(12)) u_apb_uart_top (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rxd(rxd), .txd(txd), .irq(irq));

  initial pclk = 1'b0;
  always #2.5 pclk = ~pclk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1;
    #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic send_rx(input logic [7:0] d, input bit use_par, input bit pv, input bit sv);
    @(negedge pclk); rxd = 0; repeat (BP) @(negedge pclk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BP) @(negedge pclk); end
    if (use_par) begin rxd = pv; repeat (BP) @(negedge pclk); end
    rxd = sv; repeat (BP) @(negedge pclk);
    rxd = 1; repeat (BP) @(negedge pclk);
  endtask

  // captures one frame from txd; start-bit timing is exact when data bit 0 is 1
  task automatic grab_tx(input bit use_par, output logic [7:0] d, output logic p,
                         output logic s, output int slen);
    slen = 0;
    while (txd) @(negedge pclk);
    while (!txd) begin slen++; @(negedge pclk); end
    repeat (BP / 2) @(negedge pclk);
    d[0] = txd;
    for (int i = 1; i < 8; i++) begin repeat (BP) @(negedge pclk); d[i] = txd; end
    p = 1'b0;
    if (use_par) begin repeat (BP) @(negedge pclk); p = txd; end
    repeat (BP) @(negedge pclk); s = txd;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  d;
    logic        p, s;
    int          slen, hi;
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; rxd = 1;
    repeat (4) @(negedge pclk);
    presetn = 1;
    repeat (4) @(negedge pclk);

    // R1 reset values
    rd(5'h08, v); chk("R1 ctrl", v, 32'h8000_0000);
    rd(5'h04, v); chk("R1 status", v, 32'h0000_0086);
    chk("R1 txd", {31'd0, txd}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr(5'h0C, RELOAD);
    rd(5'h0C, v); chk("R4 scaler readback", v, RELOAD);

    // R2 loopback round trip
    wr(5'h08, 32'h83);
    expq = {8'hA5, 8'h3C, 8'hFF};
    foreach (expq[i]) wr(5'h00, {24'd0, expq[i]});
    repeat (1000) @(negedge pclk);
    rd(5'h04, v);
    chk("R2 data ready", {31'd0, v[0]}, 32'd1);
    chk("R8 rx count", {26'd0, v[31:26]}, 32'd3);
    while (expq.size() > 0) begin
      rd(5'h00, v); chk("R2 order", {24'd0, v[7:0]}, {24'd0, expq.pop_front()});
    end
    rd(5'h04, v); chk("R2 drained", {31'd0, v[0]}, 32'd0);

    // R4 and R3 on the transmit side
    wr(5'h08, 32'h22);
    fork
      grab_tx(1, d, p, s, slen);
      wr(5'h00, 32'h01);
    join
    chk("R4 start bit length", slen, BP);
    chk("R4 data", {24'd0, d}, 32'h01);
    chk("R3 even parity bit", {31'd0, p}, 32'd1);
    chk("R4 stop bit", {31'd0, s}, 32'd1);
    repeat (3 * BP) @(negedge pclk);
    wr(5'h08, 32'h32);
    fork
      grab_tx(1, d, p, s, slen);
      wr(5'h00, 32'h07);
    join
    chk("R3 odd data", {24'd0, d}, 32'h07);
    chk("R3 odd parity bit", {31'd0, p}, 32'd0);
    repeat (3 * BP) @(negedge pclk);

    // R3 receive parity, R5 clear
    wr(5'h08, 32'h21);
    send_rx(8'h0F, 1, 0, 1);
    rd(5'h04, v); chk("R3 good parity flag", {31'd0, v[5]}, 32'd0);
    rd(5'h00, v); chk("R3 good parity byte", {24'd0, v[7:0]}, 32'h0F);
    send_rx(8'h0F, 1, 1, 1);
    rd(5'h04, v); chk("R3 bad parity flag", {31'd0, v[5]}, 32'd1);
    rd(5'h00, v); chk("R3 bad parity byte kept", {24'd0, v[7:0]}, 32'h0F);
    wr(5'h04, 32'h0);
    rd(5'h04, v); chk("R5 parity flag cleared", {31'd0, v[5]}, 32'd0);

    // R6 framing error
    wr(5'h08, 32'h01);
    send_rx(8'h55, 0, 0, 0);
    rd(5'h04, v);
    chk("R6 framing flag", {31'd0, v[6]}, 32'd1);
    chk("R6 not break", {31'd0, v[3]}, 32'd0);
    rd(5'h00, v); chk("R6 byte kept", {24'd0, v[7:0]}, 32'h55);

    // R7 break
    send_rx(8'h00, 0, 0, 0);
    rd(5'h04, v);
    chk("R7 break flag", {31'd0, v[3]}, 32'd1);
    chk("R7 nothing stored", {31'd0, v[0]}, 32'd0);
    wr(5'h04, 32'h0);
    rd(5'h04, v); chk("R5 all flags cleared", {28'd0, v[6:3]}, 32'd0);

    // R10 glitch and disabled receiver
    @(negedge pclk); rxd = 0; repeat (2 * (RELOAD + 1)) @(negedge pclk); rxd = 1;
    repeat (3 * BP) @(negedge pclk);
    rd(5'h04, v); chk("R10 glitch ignored", {31'd0, v[0]}, 32'd0);
    wr(5'h08, 32'h00);
    send_rx(8'h11, 0, 0, 1);
    rd(5'h04, v); chk("R10 rx disabled", {31'd0, v[0]}, 32'd0);

    // R8 overrun
    wr(5'h08, 32'h01);
    for (int i = 0; i < DEPTH + 1; i++) begin
      send_rx(8'h40 + 8'(i), 0, 0, 1);
      if (i < DEPTH) expq.push_back(8'h40 + 8'(i));
    end
    rd(5'h04, v);
    chk("R8 overrun", {31'd0, v[4]}, 32'd1);
    chk("R8 rx full", {31'd0, v[10]}, 32'd1);
    chk("R8 rx half", {31'd0, v[8]}, 32'd1);
    chk("R8 rx count", {26'd0, v[31:26]}, DEPTH);
    while (expq.size() > 0) begin
      rd(5'h00, v); chk("R8 kept bytes", {24'd0, v[7:0]}, {24'd0, expq.pop_front()});
    end
    wr(5'h04, 32'h0);

    // R9 transmit queue full, R11 level interrupt
    wr(5'h08, 32'h200);
    @(negedge pclk); chk("R11 tx level irq high", {31'd0, irq}, 32'd1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      wr(5'h00, 32'h60 + i);
      if (i < DEPTH) expq.push_back(8'h60 + 8'(i));
    end
    rd(5'h04, v);
    chk("R9 tx count", {26'd0, v[25:20]}, DEPTH);
    chk("R9 tx full", {31'd0, v[9]}, 32'd1);
    chk("R9 tx not empty", {31'd0, v[2]}, 32'd0);
    chk("R9 line idle while disabled", {31'd0, txd}, 32'd1);
    chk("R11 tx level irq low", {31'd0, irq}, 32'd0);
    wr(5'h08, 32'h283);
    repeat (2600) @(negedge pclk);
    chk("R11 tx level irq again", {31'd0, irq}, 32'd1);
    rd(5'h04, v);
    chk("R9 tx drained", {26'd0, v[25:20]}, 32'd0);
    chk("R4 shifter idle", {31'd0, v[1]}, 32'd1);
    while (expq.size() > 0) begin
      rd(5'h00, v); chk("R9 sent bytes", {24'd0, v[7:0]}, {24'd0, expq.pop_front()});
    end

    // R11 receive interrupt
    wr(5'h08, 32'h87);
    wr(5'h00, 32'h5A);
    repeat (400) @(negedge pclk);
    chk("R11 rx irq", {31'd0, irq}, 32'd1);
    rd(5'h00, v); chk("R11 rx byte", {24'd0, v[7:0]}, 32'h5A);
    chk("R11 rx irq cleared", {31'd0, irq}, 32'd0);

    // R11 drain pulse
    wr(5'h08, 32'h0A);
    hi = 0;
    fork
      for (int i = 0; i < 600; i++) begin @(negedge pclk); if (irq) hi++; end
      wr(5'h00, 32'h33);
    join
    chk("R11 tx drain pulse cycles", hi, 1);

    done = 1;
    finish_run();
  end
endmodule